// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low two address bits of a four-beat memory burst. When a qualified address strobe is accepted, it captures a two-bit base value and the ordering strap, then steps through the four beats. It moves forward one beat on each clock where the active-low advance input is low. It holds its place on any clock where advance is high, so a burst can be suspended and resumed. The upper address bits, the storage array and strobe arbitration belong to the surrounding logic. The load input is a single strobe that has already been qualified.

Two orderings are supported. In linear order each beat adds one, modulo four, to the base. In interleaved order each beat's address is the base XOR the beat number. The strap is sampled only together with a load. The block keeps the base and a beat index, and forms the output from these two values, so both orderings share one counter. A flag marks the fourth beat. A further advance from the fourth beat wraps the burst back to its base.

Top module: `burst_seq`

## Requirements
- R1: While reset (rstN low) is applied and after its release, burstAddr is 00 and lastBeat is 0 until the first load.
- R2: A clock edge with loadStrobe high makes burstAddr equal the startAddr value presented at that edge, with lastBeat 0, from the following cycle.
- R3: A clock edge with loadStrobe low and advN high leaves burstAddr and lastBeat unchanged.
- R4: With orderSel 0 (linear) captured at load, each clock edge with advN low and no load sets burstAddr to its previous value plus one, modulo 4 (base 01 runs 01, 10, 11, 00).
- R5: With orderSel 1 (interleaved) captured at load, the beat number k (0 to 3, advanced once per clock edge with advN low) gives burstAddr = base XOR k (base 01 runs 01, 00, 11, 10; base 10 runs 10, 11, 00, 01).
- R6: lastBeat is 1 exactly when the beat number equals 3, that is, after three advances (modulo four) since the last load.
- R7: An advance taken while lastBeat is 1 returns burstAddr to the base of the current burst and clears lastBeat.
- R8: When loadStrobe and advance are both active at the same edge, the load wins: the burst restarts at the new base on beat 0, and no advance is applied.
- R9: A change of orderSel between loads has no effect on the running burst. The ordering captured at the last load continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStrobe | input | 1 | Qualified strobe that loads a new burst base |
| startAddr | input | 2 | Base low address bits captured on a load |
| advN | input | 1 | Active-low advance to the next beat |
| orderSel | input | 1 | Ordering strap: 0 linear, 1 interleaved |
| burstAddr | output | 2 | Current low address bits of the burst |
| lastBeat | output | 1 | High on the fourth beat of the burst |

## Verification
A load and an advance can arrive on the same edge. So can a strap change and an advance within a running burst. The sweep covers every base value under both orderings, with a fixed pattern of advances and holds that passes through the wrap. Part way through each burst it flips orderSel and then asserts loadStrobe together with advN low. A cycle-level model in the bench gives the load priority and samples the strap only at load. Its expected burstAddr and lastBeat are compared every cycle, so an advance applied on the load edge, or a strap picked up mid-burst, shows up as a wrong address on the following beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_e;

  typedef struct packed {
    logic load;
    logic step;
  } burstCtrl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       loadStrobe,
  input  logic       advN,
  output burstCtrl_t ctrl
);
  always_comb begin
    ctrl.load = loadStrobe;
    ctrl.step = ~loadStrobe & ~advN;
  end
endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  burstCtrl_t            ctrl,
  input  logic [BURST_BITS-1:0] baseIn,
  input  logic                  orderIn,
  output logic [BURST_BITS-1:0] burstAddr,
  output logic                  lastBeat
);
  localparam logic [BURST_BITS-1:0] LAST_IDX = {BURST_BITS{1'b1}};

  logic [BURST_BITS-1:0] startQ;
  logic [BURST_BITS-1:0] beatQ;
  burstOrder_e           orderQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      beatQ  <= '0;
      orderQ <= ORDER_LINEAR;
    end else if (ctrl.load) begin
      startQ <= baseIn;
      beatQ  <= '0;
      orderQ <= burstOrder_e'(orderIn);
    end else if (ctrl.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  always_comb begin
    if (orderQ == ORDER_INTERLEAVE) burstAddr = startQ ^ beatQ;
    else                            burstAddr = startQ + beatQ;
    lastBeat = (beatQ == LAST_IDX);
  end

  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (burstAddr == $past(baseIn)) && !lastBeat); // R2
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> $stable(burstAddr) && $stable(lastBeat)); // R3
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && orderQ == ORDER_LINEAR) |=> burstAddr == $past(burstAddr) + 1'b1); // R4
  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && orderQ == ORDER_INTERLEAVE) |=>
      (burstAddr ^ startQ) == (($past(burstAddr) ^ $past(startQ)) + 1'b1)); // R5
  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && lastBeat) |=> (burstAddr == $past(startQ)) && !lastBeat); // R7
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(orderQ)); // R9
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  loadStrobe,
  input  logic [BURST_BITS-1:0] startAddr,
  input  logic                  advN,
  input  logic                  orderSel,
  output logic [BURST_BITS-1:0] burstAddr,
  output logic                  lastBeat
);
  burstCtrl_t ctrl;

  burst_ctrl uCtrl (
    .loadStrobe (loadStrobe),
    .advN       (advN),
    .ctrl       (ctrl)
  );

  burst_dpath #(.BURST_BITS(BURST_BITS)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .baseIn    (startAddr),
    .orderIn   (orderSel),
    .burstAddr (burstAddr),
    .lastBeat  (lastBeat)
  );
endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [1:0] startAddr = 2'b00;
  logic       advN = 1'b1;
  logic       orderSel = 1'b0;
  logic [1:0] burstAddr;
  logic       lastBeat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] mStart = 2'b00;
  logic [1:0] mBeat  = 2'b00;
  logic       mOrder = 1'b0;

  burst_seq dut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .startAddr(startAddr),
    .advN(advN), .orderSel(orderSel), .burstAddr(burstAddr), .lastBeat(lastBeat)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] expAddr();
    return mOrder ? (mStart ^ mBeat) : (mStart + mBeat);
  endfunction

  task automatic check(string tag);
    checks++;
    if (burstAddr !== expAddr() || lastBeat !== (mBeat == 2'd3)) begin
      fails++;
      $display("FAIL %s: addr=%b last=%b expected addr=%b last=%b",
               tag, burstAddr, lastBeat, expAddr(), (mBeat == 2'd3));
    end
  endtask

  task automatic cycle(input logic ld, input logic [1:0] base,
                       input logic adv, input logic ord);
    string tag;
    @(negedge clk);
    loadStrobe = ld; startAddr = base; advN = ~adv; orderSel = ord;
    if (ld && adv)         tag = "R8";
    else if (ld)           tag = "R2";
    else if (!adv)         tag = "R3";
    else if (mBeat == 2'd3) tag = "R7";
    else if (ord != mOrder) tag = "R9";
    else                   tag = mOrder ? "R5" : "R4";
    if (ld) begin
      mStart = base; mBeat = 2'd0; mOrder = ord;
    end else if (adv) begin
      mBeat = mBeat + 2'd1;
    end
    @(posedge clk);
    #5;
    check(tag);
    if (lastBeat !== (mBeat == 2'd3)) $display("  see R6 (last-beat flag)");
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] pat;
    pat = 9'b1_1110_1011;
    repeat (2) @(negedge clk);
    checks++;
    if (burstAddr !== 2'b00 || lastBeat !== 1'b0) begin
      fails++;
      $display("FAIL R1: addr=%b last=%b expected addr=00 last=0", burstAddr, lastBeat);
    end
    rstN = 1'b1;
    @(posedge clk); #5;
    check("R1");
    cycle(1'b0, 2'b11, 1'b0, 1'b1); // R1 hold after reset

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cycle(1'b1, 2'(s), 1'b0, 1'(m));
        for (int i = 0; i < 9; i++)
          cycle(1'b0, 2'(3 - s), pat[i], (i >= 5) ? ~1'(m) : 1'(m)); // R6 R9
        cycle(1'b1, 2'(s + 1), 1'b1, 1'(m)); // R8
        cycle(1'b0, 2'b00, 1'b1, 1'(m));
        cycle(1'b0, 2'b00, 1'b0, 1'(m));
      end
    end

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cycle(1'b1, 2'(s), 1'b0, 1'(m)); // R6 full sweep with wrap
        for (int i = 0; i < 5; i++) cycle(1'b0, 2'b00, 1'b1, 1'(m));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule